// File: doc/BRIEF.md
# Marker-Based Lane Deskew Unit

This block lines up a bundle of parallel lanes whose payload reaches it through paths of different fixed latency. The transmit side injects a one-cycle marker pulse on every lane in the same cycle, repeating every 16 cycles. The block watches each lane for that marker and works out how many cycles each lane leads the lane that arrives last. It then delays each early lane by that amount through a per-lane tapped shift register, so that payload and markers leave the block aligned.

Each evaluation starts after reset or after a clear pulse. It waits for the first marker on any lane. It then collects arrivals over one full marker period and computes the delays. After that it locks and reports completion. While locked, a monitor compares the aligned marker of every lane that took part against a reference lane. The reference is the lane that arrived latest. The monitor raises a valid flag once the markers coincide. Any later disagreement sets a sticky error and a per-lane error bit, and only a clear or a reset removes them. If no marker shows up at all, evaluation gives up and reports that no marker was found.

Top module: `lane_skew_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `done_o`, `valid_o`, `mon_err_o`, `seen_o` and `lane_err_o` are all zero and `code_o` reads 0 (busy).
- R2: If no marker arrives on any lane within 32 cycles after reset or clear, `done_o` rises, `code_o` reads 2 (no marker), and `valid_o` and `seen_o` stay zero.
- R3: After evaluation, `seen_o` bit n is 1 exactly when lane n carried a marker during the collection period.
- R4: `done_o` rises after the 16th rising edge that follows the edge that first samples a marker on any lane. It is still low before that edge.
- R5: Once locked, `code_o` reads 1. Every lane that saw a marker outputs the payload of the latest-arriving lane, delayed by the difference between the latest latency and its own (latency spread up to 15 cycles). Its aligned marker pulses in the same cycle as the markers of the other lanes.
- R6: `valid_o` rises no more than 17 cycles after `done_o` when the aligned markers agree. It is high only while `done_o` is high and `mon_err_o` is low.
- R7: When an active lane's aligned marker differs from the reference lane's aligned marker in some cycle while locked, `mon_err_o` goes high, the `lane_err_o` bit of that lane goes high, and `valid_o` falls.
- R8: `mon_err_o` and `lane_err_o` stay set after the lanes realign. Only a clear or a reset removes them.
- R9: A one-cycle pulse on `clr_i` makes `done_o`, `valid_o`, `mon_err_o`, `seen_o` and `lane_err_o` zero on the next cycle and starts a fresh evaluation.
- R10: A lane that carries no marker gets zero delay: its payload passes through undelayed. It never raises an error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear; restarts evaluation |
| lane_data_i | input | LANES*DW | Per-lane payload; lane n in bits n*DW +: DW |
| lane_mark_i | input | LANES | Per-lane marker pulse |
| algn_data_o | output | LANES*DW | Aligned per-lane payload |
| algn_mark_o | output | LANES | Aligned per-lane marker |
| seen_o | output | LANES | Lanes that received a marker during evaluation |
| done_o | output | 1 | Evaluation finished (locked or no marker) |
| valid_o | output | 1 | Aligned output confirmed usable |
| code_o | output | 2 | Result: 0 busy, 1 locked, 2 no marker |
| lane_err_o | output | LANES | Sticky per-lane monitor error |
| mon_err_o | output | 1 | Sticky monitor error |

## Verification
The aligned payload and markers depend combinationally on the current inputs and the registered taps. They are therefore compared in the same cycle as the drive, two nanoseconds after the falling edge and before the next rising edge, against the transmit history the bench keeps. `done_o` is checked in the exact cycle R4 fixes, counted from the cycle in which the bench first drives a marker. `valid_o`, the error flags and the clear results are one register behind their cause, so each is checked after a fixed number of steps that covers the marker period plus that register. The no-marker case is checked both before and after its 32-cycle limit.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_CALC    = 3'd2,
        ST_LOCK    = 3'd3,
        ST_NONE    = 3'd4
    } eval_st_e;

    typedef enum logic [1:0] {
        CODE_BUSY   = 2'd0,
        CODE_LOCKED = 2'd1,
        CODE_NOMARK = 2'd2
    } eval_code_e;

endpackage

// File: rtl/dsk_delay_line.sv
module dsk_delay_line #(
    parameter int W     = 9,
    parameter int DEPTH = 16,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din_i,
    input  logic [SW-1:0] sel_i,
    output logic [W-1:0]  dout_o
);

    // sr_q[0] holds the word of the previous cycle, sr_q[k] that of k+1 cycles ago
    logic [DEPTH-2:0][W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[DEPTH-3:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout_o = (sel_i == '0) ? din_i : sr_q[sel_i - SW'(1)];

endmodule

// File: rtl/dsk_eval.sv
module dsk_eval #(
    parameter int LANES   = 4,
    parameter int PERIOD  = 16,
    parameter int TIMEOUT = 32,
    localparam int PW     = $clog2(PERIOD),
    localparam int IW     = $clog2(TIMEOUT),
    localparam int RW     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [LANES-1:0]    mark_i,
    output logic [LANES*PW-1:0] dly_o,
    output logic [LANES-1:0]    seen_o,
    output logic [RW-1:0]       ref_o,
    output logic                locked_o,
    output logic                done_o,
    output logic [1:0]          code_o
);
    import dsk_pkg::*;

    typedef struct packed {
        eval_st_e                 st;
        logic [IW-1:0]            idle;
        logic [PW-1:0]            span;
        logic [PW-1:0]            ph;
        logic [PW-1:0]            first;
        logic [LANES-1:0]         seen;
        logic [LANES-1:0][PW-1:0] arr;
        logic [LANES-1:0][PW-1:0] dly;
        logic [RW-1:0]            refl;
    } eval_t;

    eval_t d, q;

    logic [LANES-1:0][PW-1:0] rel;
    logic [LANES-1:0][PW-1:0] dly_calc;
    logic [PW-1:0]            maxrel;
    logic [RW-1:0]            ref_calc;

    // arrival offsets relative to the first marker, wrapped to one period
    always_comb begin
        maxrel   = '0;
        ref_calc = '0;
        for (int l = 0; l < LANES; l++) begin
            rel[l] = q.arr[l] - q.first;
            if (q.seen[l] && rel[l] > maxrel) maxrel = rel[l];
        end
        for (int l = LANES - 1; l >= 0; l--) begin
            if (q.seen[l] && rel[l] == maxrel) ref_calc = RW'(l);
        end
        for (int l = 0; l < LANES; l++) begin
            dly_calc[l] = q.seen[l] ? (maxrel - rel[l]) : '0;
        end
    end

    always_comb begin
        d    = q;
        d.ph = q.ph + PW'(1);
        if (clr_i) begin
            d.st   = ST_HUNT;
            d.idle = '0;
            d.span = '0;
            d.seen = '0;
            d.dly  = '0;
            d.refl = '0;
        end else begin
            unique case (q.st)
                ST_HUNT: begin
                    if (|mark_i) begin
                        d.st    = ST_COLLECT;
                        d.span  = PW'(1);
                        d.first = q.ph;
                        d.seen  = mark_i;
                        for (int l = 0; l < LANES; l++) begin
                            if (mark_i[l]) d.arr[l] = q.ph;
                        end
                    end else if (q.idle == IW'(TIMEOUT - 1)) begin
                        d.st = ST_NONE;
                    end else begin
                        d.idle = q.idle + IW'(1);
                    end
                end
                ST_COLLECT: begin
                    for (int l = 0; l < LANES; l++) begin
                        if (mark_i[l] && !q.seen[l]) begin
                            d.seen[l] = 1'b1;
                            d.arr[l]  = q.ph;
                        end
                    end
                    if (q.span == PW'(PERIOD - 1)) d.st = ST_CALC;
                    else                           d.span = q.span + PW'(1);
                end
                ST_CALC: begin
                    d.dly  = dly_calc;
                    d.refl = ref_calc;
                    d.st   = ST_LOCK;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dly_o    = q.dly;
    assign seen_o   = q.seen;
    assign ref_o    = q.refl;
    assign locked_o = (q.st == ST_LOCK);
    assign done_o   = (q.st == ST_LOCK) || (q.st == ST_NONE);

    always_comb begin
        unique case (q.st)
            ST_LOCK: code_o = CODE_LOCKED;
            ST_NONE: code_o = CODE_NOMARK;
            default: code_o = CODE_BUSY;
        endcase
    end

endmodule

// File: rtl/dsk_monitor.sv
module dsk_monitor #(
    parameter int LANES = 4,
    localparam int RW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             locked_i,
    input  logic [LANES-1:0] active_i,
    input  logic [RW-1:0]    ref_i,
    input  logic [LANES-1:0] amark_i,
    output logic             valid_o,
    output logic             err_o,
    output logic [LANES-1:0] status_o
);

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [LANES-1:0] status;
    } mon_t;

    mon_t d, q;
    logic [LANES-1:0] mism;

    always_comb begin
        mism = active_i & (amark_i ^ {LANES{amark_i[ref_i]}});
        d    = q;
        if (clr_i || !locked_i) begin
            d = '0;
        end else begin
            d.err    = q.err | (|mism);
            d.status = q.status | mism;
            d.valid  = (q.valid | (amark_i[ref_i] & ~(|mism))) & ~d.err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o  = q.valid;
    assign err_o    = q.err;
    assign status_o = q.status;

endmodule

// File: rtl/lane_skew_aligner.sv
module lane_skew_aligner #(
    parameter int LANES   = 4,
    parameter int DW      = 8,
    parameter int PERIOD  = 16,
    parameter int TIMEOUT = 32,
    localparam int PW     = $clog2(PERIOD),
    localparam int RW     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [LANES*DW-1:0] lane_data_i,
    input  logic [LANES-1:0]    lane_mark_i,
    output logic [LANES*DW-1:0] algn_data_o,
    output logic [LANES-1:0]    algn_mark_o,
    output logic [LANES-1:0]    seen_o,
    output logic                done_o,
    output logic                valid_o,
    output logic [1:0]          code_o,
    output logic [LANES-1:0]    lane_err_o,
    output logic                mon_err_o
);

    logic [LANES*PW-1:0] dly;
    logic [RW-1:0]       ref_lane;
    logic                locked;

    dsk_eval #(
        .LANES(LANES), .PERIOD(PERIOD), .TIMEOUT(TIMEOUT)
    ) u_eval (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mark_i(lane_mark_i),
        .dly_o(dly), .seen_o(seen_o), .ref_o(ref_lane),
        .locked_o(locked), .done_o(done_o), .code_o(code_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DW:0] din, dout;
        assign din = {lane_mark_i[g], lane_data_i[g*DW +: DW]};
        dsk_delay_line #(.W(DW + 1), .DEPTH(PERIOD)) u_dl (
            .clk(clk), .rst_n(rst_n), .din_i(din),
            .sel_i(dly[g*PW +: PW]), .dout_o(dout)
        );
        assign algn_data_o[g*DW +: DW] = dout[DW-1:0];
        assign algn_mark_o[g]          = dout[DW];
    end

    dsk_monitor #(.LANES(LANES)) u_mon (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .locked_i(locked),
        .active_i(seen_o), .ref_i(ref_lane), .amark_i(algn_mark_o),
        .valid_o(valid_o), .err_o(mon_err_o), .status_o(lane_err_o)
    );

endmodule

// File: rtl/lane_skew_aligner_chk.sv
module lane_skew_aligner_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic [LANES-1:0] seen_o,
    input logic             done_o,
    input logic             valid_o,
    input logic [1:0]       code_o,
    input logic [LANES-1:0] lane_err_o,
    input logic             mon_err_o
);

    // R6
    valid_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (done_o && !mon_err_o && code_o == 2'd1));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_err_o && !clr_i) |=> mon_err_o);

    // R8
    lane_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((lane_err_o & $past(lane_err_o)) == $past(lane_err_o)));

    // R9
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!done_o && !valid_o && !mon_err_o && seen_o == '0 && lane_err_o == '0));

    // R7
    err_lane_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_err_o & ~seen_o) == '0);

    // R3
    seen_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> $stable(seen_o));

    // R2
    nomark_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == 2'd2) |-> (seen_o == '0 && !valid_o && done_o));

endmodule

bind lane_skew_aligner lane_skew_aligner_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .seen_o(seen_o), .done_o(done_o),
    .valid_o(valid_o), .code_o(code_o), .lane_err_o(lane_err_o), .mon_err_o(mon_err_o)
);

// File: tb/sim_lane_skew_aligner.sv
`timescale 1ns/1ps
module sim_lane_skew_aligner;
    localparam int L  = 4;
    localparam int DW = 8;
    localparam int P  = 16;
    localparam int HL = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n, clr;
    logic [L*DW-1:0] lane_data, algn_data;
    logic [L-1:0]    lane_mark, algn_mark, seen, lane_err;
    logic            done, valid, mon_err;
    logic [1:0]      code;

    lane_skew_aligner #(.LANES(L), .DW(DW), .PERIOD(P), .TIMEOUT(32)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .lane_data_i(lane_data),
        .lane_mark_i(lane_mark), .algn_data_o(algn_data), .algn_mark_o(algn_mark),
        .seen_o(seen), .done_o(done), .valid_o(valid), .code_o(code),
        .lane_err_o(lane_err), .mon_err_o(mon_err)
    );

    int checks = 0, errors = 0;
    int lat[L];
    bit men[L];
    logic [DW-1:0] hd[HL];
    bit hm[HL];
    logic [DW-1:0] txcnt = '0;
    bit mk_on = 0;
    int mk_ph = 0, cyc = 0, first_cyc = 0;
    bit track = 0, got_first = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        for (int i = HL - 1; i > 0; i--) begin hd[i] = hd[i-1]; hm[i] = hm[i-1]; end
        hd[0] = txcnt;
        hm[0] = mk_on && (mk_ph == 0);
        txcnt++;
        mk_ph = (mk_ph + 1) % P;
        for (int l = 0; l < L; l++) begin
            lane_data[l*DW +: DW] = hd[lat[l]];
            lane_mark[l]          = hm[lat[l]] & men[l];
        end
        cyc++;
        #2;
        if (track) begin
            if (!got_first && |lane_mark) begin got_first = 1; first_cyc = cyc; end
            if (got_first && cyc == first_cyc + 16) chk(done == 1'b0, "R4", done, 0);
            if (got_first && cyc == first_cyc + 17) chk(done == 1'b1, "R4", done, 1);
        end
    endtask

    function automatic int max_lat();
        int m = 0;
        for (int l = 0; l < L; l++) if (men[l] && lat[l] > m) m = lat[l];
        return m;
    endfunction

    function automatic logic [L-1:0] en_mask();
        logic [L-1:0] m;
        for (int l = 0; l < L; l++) m[l] = men[l];
        return m;
    endfunction

    // flush, clear, start markers and wait for lock; then check alignment
    task automatic lock_and_check();
        int ml;
        mk_on = 0;
        repeat (HL + 2) step();
        clr = 1; track = 1; got_first = 0;
        step();
        clr = 0; mk_on = 1; mk_ph = 0;
        step();
        // R9: clear seen on the step after the pulse
        chk(done == 1'b0 && mon_err == 1'b0 && valid == 1'b0, "R9", {done, mon_err, valid}, 0);
        chk(seen == '0 && lane_err == '0, "R9", {seen, lane_err}, 0);
        for (int i = 0; i < 60 && !done; i++) step();
        track = 0;
        chk(code == 2'd1, "R5", code, 1);
        chk(seen == en_mask(), "R3", seen, en_mask());
        repeat (18) step();
        chk(valid == 1'b1, "R6", valid, 1);
        chk(mon_err == 1'b0 && lane_err == '0, "R7", {mon_err, lane_err}, 0);
        ml = max_lat();
        for (int k = 0; k < 2 * P; k++) begin
            for (int l = 0; l < L; l++) begin
                if (men[l]) begin
                    chk(algn_data[l*DW +: DW] == hd[ml], "R5", algn_data[l*DW +: DW], hd[ml]);
                    chk(algn_mark[l] == hm[ml], "R5", algn_mark[l], hm[ml]);
                end else begin
                    chk(algn_data[l*DW +: DW] == hd[lat[l]], "R10", algn_data[l*DW +: DW], hd[lat[l]]);
                end
            end
            step();
        end
        chk(mon_err == 1'b0 && lane_err == '0, "R10", {mon_err, lane_err}, 0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < HL; i++) begin hd[i] = '0; hm[i] = 0; end
        for (int l = 0; l < L; l++) begin lat[l] = 0; men[l] = 1; end
        rst_n = 0; clr = 0; lane_data = '0; lane_mark = '0;
        repeat (3) @(negedge clk);
        #2;
        chk(done == 0 && valid == 0 && mon_err == 0, "R1", {done, valid, mon_err}, 0);
        chk(seen == '0 && lane_err == '0 && code == 2'd0, "R1", {seen, lane_err, code}, 0);
        @(negedge clk); rst_n = 1;
        step();
        chk(done == 0 && code == 2'd0 && seen == '0, "R1", {done, code, seen}, 0);

        // R2: no markers at all
        repeat (24) step();
        chk(done == 1'b0, "R2", done, 0);
        repeat (16) step();
        chk(done == 1'b1 && code == 2'd2, "R2", {done, code}, {1'b1, 2'd2});
        chk(valid == 1'b0 && seen == '0, "R2", {valid, seen}, 0);

        // directed: no skew
        lock_and_check();
        // directed: widest spread
        lat[0] = 0; lat[1] = 15; lat[2] = 7; lat[3] = 15;
        lock_and_check();
        // random latencies
        for (int t = 0; t < 4; t++) begin
            for (int l = 0; l < L; l++) lat[l] = $urandom % 16;
            lock_and_check();
        end
        // R10: lane 2 never carries a marker
        for (int l = 0; l < L; l++) lat[l] = $urandom % 16;
        men[2] = 0;
        lock_and_check();
        men[2] = 1;

        // R7 / R8: disturb lane 1 after lock
        lat[0] = 3; lat[1] = 9; lat[2] = 0; lat[3] = 12;
        lock_and_check();
        lat[1] = 10;
        repeat (40) step();
        chk(mon_err == 1'b1, "R7", mon_err, 1);
        chk(lane_err == 4'b0010, "R7", lane_err, 4'b0010);
        chk(valid == 1'b0, "R7", valid, 0);
        lat[1] = 9;
        repeat (40) step();
        chk(mon_err == 1'b1 && lane_err == 4'b0010, "R8", {mon_err, lane_err}, {1'b1, 4'b0010});
        chk(valid == 1'b0, "R8", valid, 0);
        // R9: clear restarts and relocks cleanly
        lock_and_check();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule